// File: doc/BRIEF.md
# External Bus Read/Write Strobe Generator

This block shapes the two active-low strobes of an external memory bus that serves cartridge storage and work RAM. It also drives the enable for the data-bus output and the enable for the bus pull-ups. The block runs on a fast clock at eight times the CPU phase clock. A free-running eighth-of-a-phase counter sets where each strobe edge falls, so edges can be placed in steps of one fast tick.

The read strobe is not a read qualifier. It rests low whenever the bus is not writing, and it goes high only around a write to the non-video region. In that role it acts as a delayed, asymmetric inverse of the write strobe. It leads the write strobe's falling edge by a few ticks and trails its rising edge by a shorter time. The CPU request is sampled once per phase period, on the wrap of the counter. Every output is registered, so none of them can glitch.

Top module: `bus_strobe_gen`

## Requirements
- R1: While `rst` is high and on the first sample after it, `wrN` is 1, `rdN` is 0, `dataOe` is 0 and `pullUpEn` is 1.
- R2: In a phase period that is not a write, `rdN` stays 0 and `wrN` stays 1. Idle periods and read requests are both such periods.
- R3: Number the ticks of a write period 0 to 7. Tick 0 is the first tick after the counter wraps. `wrN` is 0 on ticks WR_FALL..WR_RISE-1 (defaults 4..6) and 1 otherwise.
- R4: `rdN` rises exactly RD_LEAD ticks (default 3) before `wrN` falls.
- R5: `rdN` falls exactly RD_LAG ticks (default 1) after `wrN` rises.
- R6: Between two back-to-back write periods, `rdN` returns to 0 for exactly one tick before it rises again.
- R7: `dataOe` is 1 only on ticks WR_FALL-OE_LEAD..WR_RISE-1 (defaults 3..6) of a write period, and so only while `rdN` is 1. `pullUpEn` is always the inverse of `dataOe`.
- R8: The request is sampled only on the clock edge on which the counter wraps from 7 to 0. Input changes at any other edge have no effect on that period.
- R9: A period is a write only when `memReq` and `wrFlag` are both 1 and `rdFlag` is 0 at the sampling edge. A write flag without `memReq`, or with `rdFlag` also set, produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 8x the phase clock |
| rst | input | 1 | Synchronous active-high reset |
| memReq | input | 1 | Memory request to the non-video region |
| wrFlag | input | 1 | CPU write flag |
| rdFlag | input | 1 | CPU read flag |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| dataOe | output | 1 | Data-bus output enable |
| pullUpEn | output | 1 | Data-bus pull-up enable |

## Verification
The bench builds the block with its default parameters: eight ticks per phase, the write strobe low on ticks 4 to 6, a lead of three ticks and a lag of one. With these values the read strobe rises on tick 1 and falls on tick 0 of the next period. Back-to-back writes therefore bring the single-tick low gap within reach. So do requests that toggle in the middle of a period, which test that sampling happens only at the wrap.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

  // Strobe requests produced by the control for the next fast tick
  typedef struct packed {
    logic wrLow;     // write strobe asserted
    logic rdHigh;    // read strobe released
    logic busDrive;  // drive the data bus (pull-ups off)
  } strobe_t;

endpackage

// File: rtl/bus_strobe_ctrl.sv
module bus_strobe_ctrl
  import bus_strobe_pkg::*;
#(
  parameter int TICKS   = 8,
  parameter int WR_FALL = 4,
  parameter int WR_RISE = 7,
  parameter int RD_LEAD = 3,
  parameter int RD_LAG  = 1,
  parameter int OE_LEAD = 1
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    memReq,
  input  logic    wrFlag,
  input  logic    rdFlag,
  output strobe_t nextStb
);

  localparam int PW       = $clog2(TICKS);
  localparam int RD_RISE  = WR_FALL - RD_LEAD;
  localparam int RD_FALL  = WR_RISE + RD_LAG;
  localparam int OE_START = WR_FALL - OE_LEAD;
  localparam logic [PW-1:0] LAST_TICK = PW'(TICKS - 1);

  logic [PW-1:0] phase;
  logic [PW-1:0] phaseNext;
  logic          wrCycle;
  logic          wrCycleNext;
  logic          isWrite;

  assign isWrite = memReq && wrFlag && !rdFlag;

  always_comb begin
    if (phase == LAST_TICK) begin
      phaseNext   = '0;
      wrCycleNext = isWrite;
    end else begin
      phaseNext   = phase + 1'b1;
      wrCycleNext = wrCycle;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      wrCycle <= 1'b0;
    end else begin
      phase   <= phaseNext;
      wrCycle <= wrCycleNext;
    end
  end

  always_comb begin
    nextStb.wrLow    = wrCycleNext && (int'(phaseNext) >= WR_FALL)
                                   && (int'(phaseNext) <  WR_RISE);
    nextStb.rdHigh   = wrCycleNext && (int'(phaseNext) >= RD_RISE)
                                   && (int'(phaseNext) <  RD_FALL);
    nextStb.busDrive = wrCycleNext && (int'(phaseNext) >= OE_START)
                                   && (int'(phaseNext) <  WR_RISE);
  end

endmodule

// File: rtl/bus_strobe_datapath.sv
module bus_strobe_datapath
  import bus_strobe_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  strobe_t nextStb,
  output logic    rdN,
  output logic    wrN,
  output logic    dataOe,
  output logic    pullUpEn
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wrN      <= 1'b1;
      rdN      <= 1'b0;
      dataOe   <= 1'b0;
      pullUpEn <= 1'b1;
    end else begin
      wrN      <= !nextStb.wrLow;
      rdN      <= nextStb.rdHigh;
      dataOe   <= nextStb.busDrive;
      pullUpEn <= !nextStb.busDrive;
    end
  end

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bus_strobe_pkg::*;
#(
  parameter int TICKS   = 8,
  parameter int WR_FALL = 4,
  parameter int WR_RISE = 7,
  parameter int RD_LEAD = 3,
  parameter int RD_LAG  = 1,
  parameter int OE_LEAD = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic memReq,
  input  logic wrFlag,
  input  logic rdFlag,
  output logic rdN,
  output logic wrN,
  output logic dataOe,
  output logic pullUpEn
);

  strobe_t nextStb;

  bus_strobe_ctrl #(
    .TICKS(TICKS), .WR_FALL(WR_FALL), .WR_RISE(WR_RISE),
    .RD_LEAD(RD_LEAD), .RD_LAG(RD_LAG), .OE_LEAD(OE_LEAD)
  ) u_ctrl (
    .clk(clk), .rst(rst), .memReq(memReq), .wrFlag(wrFlag),
    .rdFlag(rdFlag), .nextStb(nextStb)
  );

  bus_strobe_datapath u_dp (
    .clk(clk), .rst(rst), .nextStb(nextStb),
    .rdN(rdN), .wrN(wrN), .dataOe(dataOe), .pullUpEn(pullUpEn)
  );

endmodule

// File: rtl/bus_strobe_gen_chk.sv
module bus_strobe_gen_chk #(
  parameter int RD_LEAD = 3,
  parameter int RD_LAG  = 1
) (
  input logic clk,
  input logic rst,
  input logic rdN,
  input logic wrN,
  input logic dataOe,
  input logic pullUpEn
);

  logic [7:0] rdHighCnt;
  logic [7:0] wrHighCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdHighCnt <= '0;
      wrHighCnt <= '0;
    end else begin
      rdHighCnt <= rdN ? ((rdHighCnt == 8'hFF) ? rdHighCnt : rdHighCnt + 8'd1) : 8'd0;
      wrHighCnt <= wrN ? ((wrHighCnt == 8'hFF) ? wrHighCnt : wrHighCnt + 8'd1) : 8'd0;
    end
  end

  p_wr_inside_rd_r3: assert property (@(posedge clk) disable iff (rst)
    !wrN |-> rdN);

  p_lead_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(wrN) |-> (int'(rdHighCnt) == RD_LEAD));

  p_lag_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(rdN) |-> (int'(wrHighCnt) == RD_LAG));

  p_rise_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(rdN) |-> (wrN && !dataOe));

  p_oe_needs_rd_r7: assert property (@(posedge clk) disable iff (rst)
    dataOe |-> rdN);

  p_pull_excl_r7: assert property (@(posedge clk) disable iff (rst)
    pullUpEn != dataOe);

endmodule

bind bus_strobe_gen bus_strobe_gen_chk #(.RD_LEAD(RD_LEAD), .RD_LAG(RD_LAG)) u_chk (
  .clk(clk), .rst(rst), .rdN(rdN), .wrN(wrN), .dataOe(dataOe), .pullUpEn(pullUpEn)
);

// File: tb/bus_strobe_gen_bench.sv
module bus_strobe_gen_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic memReq = 1'b0, wrFlag = 1'b0, rdFlag = 1'b0;
  logic rdN, wrN, dataOe, pullUpEn;

  int checks = 0, fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model state
  int  mPh = 0;
  bit  mWr = 1'b0;

  // edge timestamps
  int rdRiseAt = -100, rdFallAt = -100, wrRiseAt = -100, wrFallAt = -100;
  logic prevRd = 1'b0, prevWr = 1'b1;

  always #4 clk = ~clk;

  bus_strobe_gen u_bus_strobe_gen (
    .clk(clk), .rst(rst), .memReq(memReq), .wrFlag(wrFlag), .rdFlag(rdFlag),
    .rdN(rdN), .wrN(wrN), .dataOe(dataOe), .pullUpEn(pullUpEn)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  // behavioural model: one request sample per 8-tick period
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mPh = 0;
      mWr = 1'b0;
    end else begin
      mPh = (mPh + 1) % 8;
      if (mPh == 0) mWr = memReq && wrFlag && !rdFlag;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit eWrLow, eRdHigh, eOe;
      eWrLow  = mWr && mPh >= 4 && mPh < 7;
      eRdHigh = mWr && mPh >= 1;
      eOe     = mWr && mPh >= 3 && mPh < 7;
      check(tag, "wrN", int'(wrN), int'(!eWrLow));
      check(tag, "rdN", int'(rdN), int'(eRdHigh));
      check(tag, "dataOe", int'(dataOe), int'(eOe));
      check("R7", "pullUpEn", int'(pullUpEn), int'(!eOe));
      if (!rst) begin
        if (prevWr && !wrN) begin
          wrFallAt = cyc;
          check("R4", "rd lead", wrFallAt - rdRiseAt, 3);
        end
        if (!prevWr && wrN) wrRiseAt = cyc;
        if (!prevRd && rdN) begin
          if (tag == "R6" && cyc - rdFallAt < 4)
            check("R6", "rd low gap", cyc - rdFallAt, 1);
          rdRiseAt = cyc;
        end
        if (prevRd && !rdN) begin
          rdFallAt = cyc;
          check("R5", "rd lag", rdFallAt - wrRiseAt, 1);
        end
      end
      prevRd = rdN;
      prevWr = wrN;
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic m, input logic w, input logic r);
    memReq = m; wrFlag = w; rdFlag = r;
  endtask

  initial begin
    tag = "R1";
    ticks(3);
    check("R1", "reset wrN", int'(wrN), 1);
    check("R1", "reset rdN", int'(rdN), 0);
    check("R1", "reset dataOe", int'(dataOe), 0);
    check("R1", "reset pullUpEn", int'(pullUpEn), 1);
    rst = 1'b0;
    ticks(1);
    tag = "R2";
    ticks(20);
    drive(1, 0, 1);               // read requests keep rd low
    ticks(24);
    drive(0, 0, 0);
    ticks(8);
    tag = "R3";
    drive(1, 1, 0);
    ticks(8);
    drive(0, 0, 0);
    ticks(16);
    tag = "R6";
    drive(1, 1, 0);
    ticks(32);
    drive(0, 0, 0);
    ticks(16);
    tag = "R8";
    for (int i = 0; i < 60; i++) begin
      drive(1, (i % 3) == 0, 0);
      ticks(1);
    end
    drive(0, 0, 0);
    ticks(16);
    tag = "R9";
    drive(0, 1, 0);
    ticks(24);
    drive(1, 1, 1);
    ticks(24);
    drive(0, 0, 0);
    ticks(8);
    tag = "R7";
    for (int i = 0; i < 2000; i++) begin
      drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
      ticks(1);
    end
    drive(0, 0, 0);
    ticks(16);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule